// File: doc/BRIEF.md
# ADC Sequencing Controller with Averaging

This block sits between a register bus and an external successive-approximation converter. Software programs a clock register that sets the converter clock as a separately timed high phase and low phase, both counted in bus-clock cycles. It then issues one write to the control register. That write picks the input channel, the averaging depth and the reference, and it also starts the conversion.

The controller issues one-cycle sample requests on rising edges of the divided clock. It accumulates the returned 10-bit samples and divides the sum by the number of samples with a right shift. When the last sample has arrived, it raises a level interrupt. Reading the result register returns the average and drops the interrupt. Writing zero to the control register returns the block to its idle, disabled state.

Registers are word addressed: 0 is control/status, 1 is the clock register and 2 is the result register. Reads return data in the same cycle that the read strobe is high.

Top module: `adc_seq_ctrl`

## Requirements
- R1: Control word fields are: bit 0 start, bits 3:1 channel, bit 4 enable, bits 8:5 averaging setting, bit 9 internal reference. While a conversion runs, `cnv_chan` carries the selected channel and `cnv_ref_int` carries bit 9.
- R2: An averaging setting of 0 takes exactly one sample, and the result equals that sample.
- R3: An averaging setting N from 1 to 15 takes exactly 2^N samples, and the result is floor(sum / 2^N). With N = 15 and every sample at 1023, the result is 1023, so the accumulator does not overflow.
- R4: A read of address 2 returns the 10-bit result in bits 9:0, and bits 31:10 read as zero.
- R5: `irq` goes high when the last sample is taken and stays high until address 2 is read. The read clears it. Reading address 0 does not clear it.
- R6: Clock register bits 3:0 hold the low-phase count and bits 7:4 hold the high-phase count. After the enable bit is set, `cnv_clk` is high for the high count and low for the low count, so the period is their sum. A count of 0 acts as 1.
- R7: Bit 0 of the control register reads 1 while a conversion is running. It clears itself when the last sample is taken.
- R8: A control write with the enable bit set, made while a conversion is running, is ignored. The write does not change the sample count or the channel.
- R9: A control write with the enable bit clear aborts any conversion. It holds `cnv_clk` low, issues no requests and drops `irq`.
- R10: `irq` is never high while the enable bit is clear. A start written with the enable bit clear does not start a conversion.
- R11: `cnv_req` is a one-cycle pulse. It is high only in the first cycle of a high phase of `cnv_clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the read strobe |
| cnv_clk | output | 1 | Divided converter clock |
| cnv_req | output | 1 | One-cycle sample request |
| cnv_chan | output | 3 | Channel that is being sampled |
| cnv_ref_int | output | 1 | High when the internal reference is selected |
| cnv_valid | input | 1 | One-cycle pulse marking a returned sample |
| cnv_data | input | 10 | Returned sample |
| irq | output | 1 | Conversion-done interrupt, level |

## Verification
The bench sweeps all 256 high/low phase pairs, including the zero counts. A divider that did not map zero to one would stall or miscount there. It then runs every channel against averaging depths 0 to 3 and compares each result with a sum the bench computes itself. A wrong sample count or a wrong shift shows up as an extra request or an off result. A depth-15 run with full-scale samples exposes a narrow accumulator, because the result wraps below 1023. Mid-conversion starts, zero writes and enable-clear starts probe the three ways a sloppy sequencer misbehaves: it restarts or changes channel, it keeps clocking after an abort, or it raises an interrupt while disabled.

// File: rtl/adc_seq_pkg.sv
// Shared constants for the ADC sequencing controller: register word
// addresses and the fixed bus width. Assumes a word-addressed bus.
package adc_seq_pkg;
    localparam int BUS_W  = 32;
    localparam int ADDR_W = 2;
    localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] A_CLK  = 2'd1;
    localparam logic [ADDR_W-1:0] A_RES  = 2'd2;
endpackage

// File: rtl/adc_seq_clkdiv.sv
// Converter clock divider. It produces a clock with separately programmed
// low and high phase lengths, starting low when run rises. A zero count acts
// as one. rise_now flags the cycle just before the clock goes high.
// Assumes the counts may change at any time; an oversized count is absorbed.
module adc_seq_clkdiv #(
    parameter int PH_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [PH_W-1:0] lo_cnt,
    input  logic [PH_W-1:0] hi_cnt,
    output logic            div_clk,
    output logic            rise_now
);
    logic [PH_W-1:0] cnt_q;
    logic [PH_W-1:0] lo_eff, hi_eff, len;
    logic            div_q, phase_end;

    // Effective phase lengths with zero promoted to one
    always_comb begin
        lo_eff    = (lo_cnt == '0) ? PH_W'(1) : lo_cnt;
        hi_eff    = (hi_cnt == '0) ? PH_W'(1) : hi_cnt;
        len       = div_q ? hi_eff : lo_eff;
        phase_end = (cnt_q >= len - PH_W'(1));
        rise_now  = run && !div_q && phase_end;
    end

    // Phase counter and clock toggle
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
            div_q <= 1'b0;
        end else if (phase_end) begin
            cnt_q <= '0;
            div_q <= !div_q;
        end else begin
            cnt_q <= cnt_q + PH_W'(1);
        end
    end

    assign div_clk = div_q;
endmodule

// File: rtl/adc_seq_avg.sv
// Averaging accumulator. clr zeroes it; add folds in one sample. mean is the
// running sum including the present sample, shifted right by the depth.
// Assumes ACC_W leaves room for 2^MAX_SHIFT full-scale samples.
module adc_seq_avg #(
    parameter int DATA_W = 10,
    parameter int SH_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              add,
    input  logic [DATA_W-1:0] sample,
    input  logic [SH_W-1:0]   shift,
    output logic [DATA_W-1:0] mean
);
    localparam int ACC_W = DATA_W + (1 << SH_W) - 1;

    logic [ACC_W-1:0] acc_q, sum;

    // Sum including the sample that arrives this cycle, then scaled
    always_comb begin
        sum  = acc_q + ACC_W'(sample);
        mean = DATA_W'(sum >> shift);
    end

    // Accumulator register
    always_ff @(posedge clk) begin
        if (!rst_n || clr) acc_q <= '0;
        else if (add)      acc_q <= sum;
    end
endmodule

// File: rtl/adc_seq_ctrl.sv
// ADC sequencing controller top. It holds the control, clock and result
// registers. A single control write selects channel, depth and reference
// and starts a run of 2^depth conversions. Each request goes out on a
// divided-clock rising edge, one request at a time. Completion raises a
// level interrupt that a result read clears. Assumes the converter answers
// each request with one cnv_valid pulse.
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int DATA_W = 10,
    parameter int CH_W   = 3,
    parameter int AVG_W  = 4,
    parameter int PH_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              cnv_clk,
    output logic              cnv_req,
    output logic [CH_W-1:0]   cnv_chan,
    output logic              cnv_ref_int,
    input  logic              cnv_valid,
    input  logic [DATA_W-1:0] cnv_data,
    output logic              irq
);
    localparam int CH_LSB  = 1;
    localparam int EN_BIT  = CH_LSB + CH_W;
    localparam int AVG_LSB = EN_BIT + 1;
    localparam int REF_BIT = AVG_LSB + AVG_W;
    localparam int CNT_W   = 1 << AVG_W;

    logic              en_q, ref_q, busy_q, pend_q, wait_q, req_q;
    logic [CH_W-1:0]   chan_q;
    logic [AVG_W-1:0]  avg_q;
    logic [PH_W-1:0]   lo_q, hi_q;
    logic [CNT_W-1:0]  smp_q;
    logic [DATA_W-1:0] res_q, mean;
    logic              wr_ctrl, wr_clk, rd_res, w_en, start_ok, abort;
    logic              rise_now, take, last_smp;

    // Decode of bus strobes and sequencing events
    always_comb begin
        wr_ctrl  = bus_wr && (bus_addr == A_CTRL);
        wr_clk   = bus_wr && (bus_addr == A_CLK);
        rd_res   = bus_rd && (bus_addr == A_RES);
        w_en     = bus_wdata[EN_BIT];
        abort    = wr_ctrl && !w_en;
        start_ok = wr_ctrl && w_en && bus_wdata[0] && !busy_q;
        take     = busy_q && wait_q && cnv_valid;
        last_smp = (smp_q == ((CNT_W'(1) << avg_q) - CNT_W'(1)));
    end

    adc_seq_clkdiv #(.PH_W(PH_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (en_q),
        .lo_cnt   (lo_q),
        .hi_cnt   (hi_q),
        .div_clk  (cnv_clk),
        .rise_now (rise_now)
    );

    adc_seq_avg #(.DATA_W(DATA_W), .SH_W(AVG_W)) u_avg (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (start_ok),
        .add    (take),
        .sample (cnv_data),
        .shift  (avg_q),
        .mean   (mean)
    );

    // Control fields: loaded unless a running conversion would be disturbed
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            ref_q  <= 1'b0;
            chan_q <= '0;
            avg_q  <= '0;
        end else if (wr_ctrl && (!w_en || !busy_q)) begin
            en_q   <= w_en;
            ref_q  <= bus_wdata[REF_BIT];
            chan_q <= bus_wdata[CH_LSB +: CH_W];
            avg_q  <= bus_wdata[AVG_LSB +: AVG_W];
        end
    end

    // Clock phase register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else if (wr_clk) begin
            lo_q <= bus_wdata[0 +: PH_W];
            hi_q <= bus_wdata[PH_W +: PH_W];
        end
    end

    // Sequencer: busy flag, outstanding request, request pulse, sample count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            wait_q <= 1'b0;
            req_q  <= 1'b0;
            smp_q  <= '0;
        end else begin
            req_q <= 1'b0;
            if (abort) begin
                busy_q <= 1'b0;
                wait_q <= 1'b0;
            end else if (start_ok) begin
                busy_q <= 1'b1;
                wait_q <= 1'b0;
                smp_q  <= '0;
            end else if (busy_q) begin
                if (rise_now && !wait_q) begin
                    req_q  <= 1'b1;
                    wait_q <= 1'b1;
                end
                if (take) begin
                    wait_q <= 1'b0;
                    smp_q  <= smp_q + CNT_W'(1);
                    if (last_smp) busy_q <= 1'b0;
                end
            end
        end
    end

    // Result register and pending interrupt
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q  <= '0;
            pend_q <= 1'b0;
        end else if (abort || start_ok) begin
            pend_q <= 1'b0;
        end else if (take && last_smp) begin
            res_q  <= mean;
            pend_q <= 1'b1;
        end else if (rd_res) begin
            pend_q <= 1'b0;
        end
    end

    // Read mux
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL: begin
                bus_rdata[0]                 = busy_q;
                bus_rdata[CH_LSB +: CH_W]    = chan_q;
                bus_rdata[EN_BIT]            = en_q;
                bus_rdata[AVG_LSB +: AVG_W]  = avg_q;
                bus_rdata[REF_BIT]           = ref_q;
            end
            A_CLK:   bus_rdata[0 +: 2*PH_W] = {hi_q, lo_q};
            A_RES:   bus_rdata[0 +: DATA_W] = res_q;
            default: bus_rdata = '0;
        endcase
    end

    assign cnv_req     = req_q;
    assign cnv_chan    = chan_q;
    assign cnv_ref_int = ref_q;
    assign irq         = pend_q && en_q;
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
// Protocol checker for adc_seq_ctrl, bound to the top. It observes ports
// and the busy/enable state and checks request timing, interrupt clearing,
// channel stability and idle behaviour.
module adc_seq_ctrl_chk #(
    parameter int CH_W = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            bus_wr,
    input logic            bus_rd,
    input logic [1:0]      bus_addr,
    input logic            cnv_clk,
    input logic            cnv_req,
    input logic [CH_W-1:0] cnv_chan,
    input logic            irq,
    input logic            busy,
    input logic            en
);
    // R11: request only on the first high cycle of the divided clock
    p_req_on_rise_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cnv_req |-> (cnv_clk && !$past(cnv_clk)));

    // R11: request lasts one cycle
    p_req_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cnv_req |=> !cnv_req);

    // R5: a result read with no write and no run in flight clears irq
    p_irq_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 2'd2 && !bus_wr && !busy) |=> !irq);

    // R1: channel held steady through a running conversion
    p_chan_stable_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(cnv_chan));

    // R9: clock stays low once enable is clear
    p_idle_clk_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !cnv_clk);

    // R8: requests only while a conversion runs
    p_req_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cnv_req |-> busy);
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.CH_W(CH_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .cnv_clk  (cnv_clk),
    .cnv_req  (cnv_req),
    .cnv_chan (cnv_chan),
    .irq      (irq),
    .busy     (busy_q),
    .en       (en_q)
);

// File: tb/adc_seq_ctrl_bench.sv
// Self-checking bench: sweeps divider phases, channel/depth combinations,
// and the abort, ignore and full-depth corner cases.
module adc_seq_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        cnv_clk, cnv_req, cnv_ref_int, irq;
    logic [2:0]  cnv_chan;
    logic        cnv_valid = 1'b0;
    logic [9:0]  cnv_data = '0;

    int errors = 0, checks = 0, cycles = 0;
    int nreq = 0;
    int bad_chan = 0;
    int exp_chan = 0;
    bit force_full = 1'b0;

    always #2.5 clk = !clk;

    adc_seq_ctrl u_adc_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cnv_clk(cnv_clk), .cnv_req(cnv_req), .cnv_chan(cnv_chan),
        .cnv_ref_int(cnv_ref_int), .cnv_valid(cnv_valid),
        .cnv_data(cnv_data), .irq(irq)
    );

    function automatic int sample_of(int ch, int k);
        if (force_full) return 1023;
        return (ch * 97 + k * 53 + 11) % 1024;
    endfunction

    // Converter model: answers each request at the following negedge
    always @(negedge clk) begin
        cnv_valid = 1'b0;
        if (cnv_req) begin
            if (int'(cnv_chan) != exp_chan) bad_chan++;
            cnv_valid = 1'b1;
            cnv_data  = 10'(sample_of(int'(cnv_chan), nreq));
            nreq++;
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 195000) begin
            errors++;
            $display("FAIL watchdog: act=%0d exp<=%0d", cycles, 195000);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0; bus_addr = '0;
    endtask

    function automatic logic [31:0] ctrl_word(int st, int ch, int en, int av, int rf);
        return 32'(st) | (32'(ch) << 1) | (32'(en) << 4) | (32'(av) << 5) | (32'(rf) << 9);
    endfunction

    task automatic wait_irq(input int limit);
        int n = 0;
        while (!irq && n < limit) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic measure(input int hi, input int lo);
        int nh = 0, nl = 0, guard = 0;
        wr(2'd0, 32'd0);
        wr(2'd1, 32'((hi << 4) | lo));
        wr(2'd0, ctrl_word(0, 0, 1, 0, 0));
        while (!cnv_clk && guard < 100) begin
            @(negedge clk);
            guard++;
        end
        while (cnv_clk && nh < 40) begin nh++; @(negedge clk); end
        while (!cnv_clk && nl < 40) begin nl++; @(negedge clk); end
        check(nh == ((hi == 0) ? 1 : hi), "R6 high phase", nh, (hi == 0) ? 1 : hi);
        check(nl == ((lo == 0) ? 1 : lo), "R6 low phase", nl, (lo == 0) ? 1 : lo);
    endtask

    task automatic convert(input int ch, input int av, input int rf);
        logic [31:0] d;
        int sum = 0, expv, cnt;
        for (int k = 0; k < (1 << av); k++) sum += sample_of(ch, k);
        expv = sum >> av;
        nreq = 0; bad_chan = 0; exp_chan = ch;
        wr(2'd0, ctrl_word(1, ch, 1, av, rf));
        check(cnv_ref_int == rf[0], "R1 reference select", int'(cnv_ref_int), rf);
        rd(2'd0, d);
        check(d[0] == 1'b1, "R7 start reads 1 while running", int'(d[0]), 1);
        wait_irq(200000);
        cnt = nreq;
        if (av == 0) check(cnt == 1, "R2 single sample", cnt, 1);
        else         check(cnt == (1 << av), "R3 sample count", cnt, 1 << av);
        check(bad_chan == 0, "R1 channel on requests", bad_chan, 0);
        rd(2'd0, d);
        check(d[0] == 1'b0, "R7 start self-clears", int'(d[0]), 0);
        check(irq == 1'b1, "R5 irq held across control read", int'(irq), 1);
        rd(2'd2, d);
        check(d == 32'(expv), av == 0 ? "R2 result" : "R3 result", int'(d), expv);
        check(d[31:10] == '0, "R4 upper bits zero", int'(d[31:10]), 0);
        check(irq == 1'b0, "R5 irq cleared by result read", int'(irq), 0);
    endtask

    initial begin
        logic [31:0] d;
        int base, hold;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(irq == 1'b0 && cnv_clk == 1'b0 && cnv_req == 1'b0, "R9 reset idle",
              int'({irq, cnv_clk, cnv_req}), 0);
        rd(2'd0, d);
        check(d == 32'd0, "R9 reset control", int'(d), 0);

        // R6: exhaustive phase sweep
        for (int hi = 0; hi < 16; hi++)
            for (int lo = 0; lo < 16; lo++)
                measure(hi, lo);

        // R1 R2 R3 R4 R5 R7: channel x depth sweep
        wr(2'd0, 32'd0);
        wr(2'd1, 32'h12);
        for (int ch = 0; ch < 8; ch++)
            for (int av = 0; av < 4; av++)
                convert(ch, av, (ch + av) % 2);

        // R8: enabled start written during a run is ignored
        nreq = 0; bad_chan = 0; exp_chan = 5;
        wr(2'd0, ctrl_word(1, 5, 1, 3, 0));
        hold = 0;
        while (nreq == 0 && hold < 100) begin @(negedge clk); hold++; end
        wr(2'd0, ctrl_word(1, 2, 1, 1, 1));
        wait_irq(2000);
        check(nreq == 8, "R8 count unchanged by mid-run start", nreq, 8);
        check(bad_chan == 0, "R8 channel unchanged", bad_chan, 0);
        check(cnv_ref_int == 1'b0, "R8 reference unchanged", int'(cnv_ref_int), 0);

        // R9: zero write aborts and idles
        wr(2'd0, 32'd0);
        base = nreq; hold = 0;
        for (int i = 0; i < 40; i++) begin
            if (cnv_clk || irq) hold++;
            @(negedge clk);
        end
        check(hold == 0, "R9 clock and irq low after zero write", hold, 0);
        check(nreq == base, "R9 no requests after zero write", nreq, base);

        // R9: abort mid-run
        nreq = 0; exp_chan = 4;
        wr(2'd0, ctrl_word(1, 4, 1, 3, 0));
        while (nreq < 2) @(negedge clk);
        wr(2'd0, 32'd0);
        base = nreq;
        repeat (40) @(negedge clk);
        check(nreq == base && irq == 1'b0, "R9 abort stops requests", nreq, base);

        // R10: start with enable clear does nothing
        nreq = 0; hold = 0;
        wr(2'd0, ctrl_word(1, 3, 0, 0, 0));
        for (int i = 0; i < 40; i++) begin
            if (irq) hold++;
            @(negedge clk);
        end
        check(nreq == 0, "R10 no conversion without enable", nreq, 0);
        check(hold == 0, "R10 irq low while disabled", hold, 0);
        rd(2'd0, d);
        check(d[0] == 1'b0 && d[4] == 1'b0, "R10 control shows idle", int'(d[4:0]) & 17, 0);

        // R3: full depth, full scale, zero phase counts
        force_full = 1'b1;
        wr(2'd1, 32'd0);
        convert(6, 15, 0);
        force_full = 1'b0;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule